// File: doc/BRIEF.md
# Receive/Transmit FIFO Occupancy with DMA Ready Strobes

This block sits between a serial receiver, a serial transmitter and a DMA controller. It stores received bytes in a byte-wide queue of parameter depth (16 by default). It counts how many bytes the transmit queue holds. From these fill levels it drives two active-low ready strobes, one for each direction, that ask the DMA controller for service. It also gives the fill levels and a flag that the interrupt logic uses when the receive queue reaches the programmed threshold.

The strobes have two meanings. In single-transfer signalling, each strobe follows a plain empty or non-empty test. This signalling is used whenever the queues are switched off, or when they are on with DMA mode at 0. In burst signalling, the queues are on and DMA mode is 1. The receive strobe then waits for the threshold or a character timeout and holds until the queue drains. The transmit strobe asks for data from empty until full. A 2-bit field selects the receive threshold. Each queue has a one-cycle flush request. Switching the queues off empties both of them.

Top module: `fifo_rdy_top`

## Requirements
- R1: After reset both levels are 0, rxReadyN is 1, txReadyN is 0, trigReached is 0 and rxOverrun is 0, and signalling is single-transfer.
- R2: With fifoEn=1 each queue holds up to DEPTH bytes. The receive queue returns bytes in arrival order, and rxData shows the oldest byte whenever rxLevel is not 0. A push and a pop in the same cycle are both applied.
- R3: With fifoEn=0 each queue holds at most one byte.
- R4: A push is refused when the level before the edge equals the capacity, and a pop in the same cycle does not make room. A refused receive push drops the byte and raises rxOverrun for exactly the next cycle. A pop from an empty queue changes nothing.
- R5: In single-transfer signalling (fifoEn=0, or dmaMode=0), rxReadyN is 0 exactly when rxLevel is not 0.
- R6: In single-transfer signalling, txReadyN is 0 exactly when txLevel is 0.
- R7: trigSel sets the threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. trigReached is 1 exactly when fifoEn=1 and rxLevel is at or above the threshold.
- R8: In burst signalling (fifoEn=1 and dmaMode=1), rxReadyN falls in the cycle after the edge at which the level reaches the threshold. It also falls in the cycle after an edge where charTimeout is high and the queue is non-empty after that edge. It then stays 0 until the queue is empty.
- R9: In burst signalling, txReadyN is 0 while txLevel is 0. It goes to 1 when txLevel reaches DEPTH and stays at 1 until txLevel returns to 0.
- R10: rxFlush or txFlush empties only its own queue at that edge. It wins over a push or pop in the same cycle, raises no overrun, and has no effect in later cycles.
- R11: At the first edge where fifoEn is 0 after being 1, both queues are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | Queue enable |
| dmaMode | input | 1 | DMA signalling select (1 = burst) |
| trigSel | input | 2 | Receive threshold select |
| rxFlush | input | 1 | One-cycle receive queue flush |
| txFlush | input | 1 | One-cycle transmit queue flush |
| rxPush | input | 1 | Received byte strobe |
| rxIn | input | 8 | Received byte |
| rxPop | input | 1 | Receive read strobe |
| txPush | input | 1 | Transmit load strobe |
| txPop | input | 1 | Transmit take strobe (byte moved to shifter) |
| charTimeout | input | 1 | Character timeout pulse from the receiver |
| rxData | output | 8 | Oldest received byte |
| rxLevel | output | 5 | Receive fill level |
| txLevel | output | 5 | Transmit fill level |
| rxReadyN | output | 1 | Receive DMA request, active low |
| txReadyN | output | 1 | Transmit DMA request, active low |
| trigReached | output | 1 | Receive threshold met |
| rxOverrun | output | 1 | One-cycle pulse for a dropped receive byte |

## Verification
The bench drives pushes into a full queue, sometimes with a pop in the same cycle. A design that lets the pop make room would store the byte instead of pulsing overrun. The bench walks all four threshold codes in burst signalling and then drains partway. A receive strobe that is only a level compare would rise again below the threshold, when it should hold until empty. The transmit strobe is checked in the same way as the queue drains from full. Flushes and the enable falling edge are applied together with pushes, so a design that gives the push priority would leave a byte behind.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;

  // Strobes from the control to the datapath, one set per clock edge.
  typedef struct packed {
    logic rxWr;
    logic rxRd;
    logic rxClr;
    logic txInc;
    logic txDec;
    logic txClr;
  } fifoStrobeT;

  localparam int TRIG_A = 1;
  localparam int TRIG_B = 4;
  localparam int TRIG_C = 8;
  localparam int TRIG_D = 14;

  function automatic int trigBytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return TRIG_A;
      2'b01:   return TRIG_B;
      2'b10:   return TRIG_C;
      default: return TRIG_D;
    endcase
  endfunction

endpackage

// File: rtl/fifo_rdy_dpath.sv
module fifo_rdy_dpath
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    strb,
  input  logic [DW-1:0] rxIn,
  output logic [DW-1:0] rxData,
  output logic [LW-1:0] rxLevel,
  output logic [LW-1:0] txLevel
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strb.rxWr && !strb.rxClr) mem[wrPtr] <= rxIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxLevel <= '0;
    end else if (strb.rxClr) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxLevel <= '0;
    end else begin
      if (strb.rxWr) wrPtr <= bump(wrPtr);
      if (strb.rxRd) rdPtr <= bump(rdPtr);
      rxLevel <= rxLevel + LW'(strb.rxWr) - LW'(strb.rxRd);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txLevel <= '0;
    else if (strb.txClr)   txLevel <= '0;
    else                   txLevel <= txLevel + LW'(strb.txInc) - LW'(strb.txDec);
  end

  assign rxData = mem[rdPtr];

endmodule

// File: rtl/fifo_rdy_ctrl.sv
module fifo_rdy_ctrl
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          dmaMode,
  input  logic [1:0]    trigSel,
  input  logic          rxFlush,
  input  logic          txFlush,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          charTimeout,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] txLevel,
  output fifoStrobeT    strb,
  output logic          rxReadyN,
  output logic          txReadyN,
  output logic          trigReached,
  output logic          rxOverrun
);

  logic          enQ, dropAll, burst;
  logic          rxHold, txFullHold;
  logic [LW-1:0] cap, thresh, rxNext, txNext;

  assign cap     = fifoEn ? LW'(DEPTH) : LW'(1);
  assign thresh  = LW'(trigBytes(trigSel));
  assign dropAll = enQ && !fifoEn;
  assign burst   = fifoEn && dmaMode;

  always_comb begin
    strb       = '0;
    strb.rxClr = rxFlush || dropAll;
    strb.txClr = txFlush || dropAll;
    strb.rxRd  = rxPop && (rxLevel != '0);
    strb.rxWr  = rxPush && (rxLevel < cap);
    strb.txDec = txPop && (txLevel != '0);
    strb.txInc = txPush && (txLevel < cap);
  end

  assign rxNext = strb.rxClr ? '0 : rxLevel + LW'(strb.rxWr) - LW'(strb.rxRd);
  assign txNext = strb.txClr ? '0 : txLevel + LW'(strb.txInc) - LW'(strb.txDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      rxHold     <= 1'b0;
      txFullHold <= 1'b0;
      rxOverrun  <= 1'b0;
    end else begin
      enQ       <= fifoEn;
      rxOverrun <= rxPush && !strb.rxClr && (rxLevel >= cap);
      rxHold    <= (rxNext != '0) && (rxHold || charTimeout || rxNext >= thresh);
      if (txNext == LW'(DEPTH))  txFullHold <= 1'b1;
      else if (txNext == '0)     txFullHold <= 1'b0;
    end
  end

  assign trigReached = fifoEn && (rxLevel >= thresh);
  assign rxReadyN    = burst ? !rxHold    : (rxLevel == '0);
  assign txReadyN    = burst ? txFullHold : (txLevel != '0);

endmodule

// File: rtl/fifo_rdy_top.sv
module fifo_rdy_top
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          dmaMode,
  input  logic [1:0]    trigSel,
  input  logic          rxFlush,
  input  logic          txFlush,
  input  logic          rxPush,
  input  logic [DW-1:0] rxIn,
  input  logic          rxPop,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          charTimeout,
  output logic [DW-1:0] rxData,
  output logic [LW-1:0] rxLevel,
  output logic [LW-1:0] txLevel,
  output logic          rxReadyN,
  output logic          txReadyN,
  output logic          trigReached,
  output logic          rxOverrun
);

  fifoStrobeT strb;

  fifo_rdy_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .dmaMode(dmaMode), .trigSel(trigSel),
    .rxFlush(rxFlush), .txFlush(txFlush), .rxPush(rxPush), .rxPop(rxPop),
    .txPush(txPush), .txPop(txPop), .charTimeout(charTimeout),
    .rxLevel(rxLevel), .txLevel(txLevel), .strb(strb),
    .rxReadyN(rxReadyN), .txReadyN(txReadyN), .trigReached(trigReached),
    .rxOverrun(rxOverrun)
  );

  fifo_rdy_dpath #(.DEPTH(DEPTH), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxIn(rxIn),
    .rxData(rxData), .rxLevel(rxLevel), .txLevel(txLevel)
  );

endmodule

// File: rtl/fifo_rdy_chk.sv
module fifo_rdy_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          fifoEn,
  input logic          dmaMode,
  input logic          rxFlush,
  input logic          txFlush,
  input logic          rxPush,
  input logic [LW-1:0] rxLevel,
  input logic [LW-1:0] txLevel,
  input logic          rxReadyN,
  input logic          txReadyN,
  input logic          trigReached,
  input logic          rxOverrun
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= LW'(DEPTH) && txLevel <= LW'(DEPTH));                       // R2

  AST_OFF_ONE_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn && $past(!fifoEn) && $past(rstN) |-> rxLevel <= LW'(1));      // R3

  AST_OVR_FROM_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxPush) && !$past(rxFlush));                       // R4

  AST_SINGLE_RX: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn || !dmaMode) |-> rxReadyN == (rxLevel == '0));                // R5

  AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txLevel == '0 |-> !txReadyN);                                          // R9

  AST_TX_FULL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txLevel == LW'(DEPTH) |-> txReadyN);                                   // R9

  AST_TRIG_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    trigReached |-> rxLevel != '0);                                        // R7

  AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxFlush) && $past(rstN) |-> rxLevel == '0);                      // R10

  AST_TX_FLUSHED: assert property (@(posedge clk) disable iff (!rstN)
    $past(txFlush) && $past(rstN) |-> txLevel == '0);                      // R10

endmodule

bind fifo_rdy_top fifo_rdy_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .dmaMode(dmaMode),
  .rxFlush(rxFlush), .txFlush(txFlush), .rxPush(rxPush),
  .rxLevel(rxLevel), .txLevel(txLevel), .rxReadyN(rxReadyN),
  .txReadyN(txReadyN), .trigReached(trigReached), .rxOverrun(rxOverrun)
);

// File: tb/sim_fifo_rdy_top.sv
`timescale 1ns/1ps
module sim_fifo_rdy_top;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEn = 0, dmaMode = 0, rxFlush = 0, txFlush = 0;
  logic rxPush = 0, rxPop = 0, txPush = 0, txPop = 0, charTimeout = 0;
  logic [1:0] trigSel = 2'b00;
  logic [7:0] rxIn = 8'h00;
  logic [7:0] rxData;
  logic [LW-1:0] rxLevel, txLevel;
  logic rxReadyN, txReadyN, trigReached, rxOverrun;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_rdy_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .dmaMode(dmaMode), .trigSel(trigSel),
    .rxFlush(rxFlush), .txFlush(txFlush), .rxPush(rxPush), .rxIn(rxIn), .rxPop(rxPop),
    .txPush(txPush), .txPop(txPop), .charTimeout(charTimeout),
    .rxData(rxData), .rxLevel(rxLevel), .txLevel(txLevel), .rxReadyN(rxReadyN),
    .txReadyN(txReadyN), .trigReached(trigReached), .rxOverrun(rxOverrun)
  );

  // Behavioural reference model
  logic [7:0] rxQ[$];
  int txCnt = 0;
  bit mLatch = 0, mHold = 0, mOvr = 0, mEnQ = 0;

  function automatic int thr(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rxQ.delete(); txCnt = 0; mLatch = 0; mHold = 0; mOvr = 0; mEnQ = 0;
    end else begin
      int cap, prev, n;
      bit clrAll;
      cap = fifoEn ? DEPTH : 1;
      clrAll = mEnQ && !fifoEn;
      mEnQ = fifoEn;
      mOvr = 0;
      if (rxFlush || clrAll) rxQ.delete();
      else begin
        prev = rxQ.size();
        if (rxPop && prev > 0) void'(rxQ.pop_front());
        if (rxPush) begin
          if (prev < cap) rxQ.push_back(rxIn); else mOvr = 1;
        end
      end
      if (txFlush || clrAll) txCnt = 0;
      else begin
        prev = txCnt;
        if (txPop && prev > 0) txCnt--;
        if (txPush && prev < cap) txCnt++;
      end
      n = rxQ.size();
      mLatch = (n != 0) && (mLatch || charTimeout || n >= thr(trigSel));
      if (txCnt == DEPTH) mHold = 1; else if (txCnt == 0) mHold = 0;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit multi;
    multi = fifoEn && dmaMode;
    chk(fifoEn ? "R2" : "R3", "rxLevel", int'(rxLevel), rxQ.size());
    chk(fifoEn ? "R2" : "R3", "txLevel", int'(txLevel), txCnt);
    chk(multi ? "R8" : "R5", "rxReadyN", int'(rxReadyN),
        multi ? int'(!mLatch) : int'(rxQ.size() == 0));
    chk(multi ? "R9" : "R6", "txReadyN", int'(txReadyN),
        multi ? int'(mHold) : int'(txCnt != 0));
    chk("R7", "trigReached", int'(trigReached), int'(fifoEn && rxQ.size() >= thr(trigSel)));
    chk("R4", "rxOverrun", int'(rxOverrun), int'(mOvr));
    if (rxQ.size() > 0) chk("R2", "rxData", int'(rxData), int'(rxQ[0]));
  endtask

  // Drive one cycle of strobes at a falling edge, compare at the next falling edge.
  task automatic step(input bit pu, input bit po, input bit tpu, input bit tpo,
                      input bit tmo = 0, input bit rfl = 0, input bit tfl = 0);
    rxPush = pu; rxPop = po; txPush = tpu; txPop = tpo;
    charTimeout = tmo; rxFlush = rfl; txFlush = tfl;
    if (pu) rxIn = 8'($urandom);
    @(posedge clk);
    @(negedge clk);
    rxPush = 0; rxPop = 0; txPush = 0; txPop = 0;
    charTimeout = 0; rxFlush = 0; txFlush = 0;
    compare();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rxLevel", int'(rxLevel), 0);
    chk("R1", "txLevel", int'(txLevel), 0);
    chk("R1", "rxReadyN", int'(rxReadyN), 1);
    chk("R1", "txReadyN", int'(txReadyN), 0);
    chk("R1", "trigReached", int'(trigReached), 0);
    chk("R1", "rxOverrun", int'(rxOverrun), 0);

    // R3/R5/R6: queues off, one-deep holding; R4 overrun and empty pop
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    chk("R4", "overrun held one-deep", int'(rxLevel), 1);
    step(0, 1, 0, 1);
    step(0, 1, 0, 1);
    chk("R4", "pop from empty", int'(rxLevel), 0);

    // R2: queues on, single-transfer, overfill and drain in order
    fifoEn = 1; dmaMode = 0;
    for (int i = 0; i < 20; i++) step(1, 0, 1, 0);
    chk("R2", "full level", int'(rxLevel), DEPTH);
    step(1, 1, 0, 0); // R4: pop does not make room
    for (int i = 0; i < 18; i++) step(0, 1, 0, 1);

    // R7/R8: burst signalling over every threshold code
    dmaMode = 1;
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      for (int i = 0; i < thr(2'(s)) + 1; i++) step(1, 0, 0, 0);
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      chk("R8", "hold below threshold", int'(rxReadyN), int'(rxLevel == 0));
      while (rxLevel != 0) step(0, 1, 0, 0);
    end

    // R8: character timeout with few bytes
    trigSel = 2'b11;
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    chk("R8", "before timeout", int'(rxReadyN), 1);
    step(0, 0, 0, 0, 1);
    chk("R8", "after timeout", int'(rxReadyN), 0);
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    step(0, 0, 0, 0, 1); // timeout on empty: no request

    // R9: transmit burst signalling
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0);
    chk("R9", "full idle", int'(txReadyN), 1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1);
    chk("R9", "empty request", int'(txReadyN), 0);

    // R10: flush wins over same-cycle push, only own queue
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0);
    step(1, 0, 1, 0, 0, 1, 0);
    chk("R10", "rx flushed", int'(rxLevel), 0);
    chk("R10", "tx untouched", int'(txLevel), 6);
    step(1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 1);
    chk("R10", "tx flushed", int'(txLevel), 0);
    chk("R10", "rx untouched", int'(rxLevel), 1);

    // R11: disabling discards both
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0);
    fifoEn = 0;
    step(1, 0, 1, 0);
    chk("R11", "rx discarded", int'(rxLevel), 0);
    chk("R11", "tx discarded", int'(txLevel), 0);
    fifoEn = 1;

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) == 0) fifoEn = ~fifoEn;
      if ($urandom_range(0, 49) == 0) dmaMode = ~dmaMode;
      if ($urandom_range(0, 49) == 0) trigSel = 2'($urandom);
      step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
           $urandom_range(0, 9) < 5, $urandom_range(0, 9) < 5,
           $urandom_range(0, 29) == 0, $urandom_range(0, 79) == 0,
           $urandom_range(0, 79) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule